// File: doc/BRIEF.md
# Start-Bit Framed Synchronous Management Port

This block is a byte-wide command port driven by an externally supplied serial clock. A controller shifts a command byte in on the serial input and, for commands that ask for one, receives a result byte on the serial output. Each byte on either line is framed as a low start bit followed by eight data bits, least significant bit first. Both lines idle high. Input sampling and output updates happen on the rising clock edge. The clock may run freely or arrive as a sparse burst of single edges, because the port counts edges and never measures time.

A command with bit 7 clear is a write. Bits 6:0 go into a 7-bit control register, and the command completes on its 14th edge with no output activity. A command with bit 7 set is a read. Bits 1:0 select one of four 8-bit sources, and the command completes on its 20th edge. The reply's start bit appears after edge 11, its data bits after edges 12 to 19, and the line returns high after edge 20. The next command's start bit may be sampled on the edge that directly follows completion. A high level on the disable input holds the port idle.

Top module: `mgmt_port`

## Requirements
- R1: After the active-low reset, `so` is high and the control register reads back as 0x00.
- R2: While idle, high levels on `si` are ignored and `so` stays high. A frame begins on the first rising edge that samples `si` low.
- R3: The command byte's bits D0..D7 are sampled on edges 2..9 of the frame, counting the start-bit edge as edge 1.
- R4: A command with bit 7 = 0 loads bits 6:0 into the control register, with bit 7 read back as 0. It leaves `so` high throughout and completes on edge 14, so a start bit on edge 15 is accepted.
- R5: A command with bit 7 = 1 drives `so` low after edge 11 and D0..D7 of the reply after edges 12..19, LSB first. `so` returns high after edge 20, and a start bit on edge 21 is accepted.
- R6: Read source by bits 1:0: 0 gives the control register, 1 gives the parameter ID_VAL (default 0xA5), 2 gives the bitwise inverse of the control register, and 3 gives the command byte received before the current one.
- R7: `si` is ignored from edge 10 up to and including the command's final edge, including low levels during the reply.
- R8: While `mgmt_dis` is high, `si` is ignored, `so` is held high, the registers keep their values, and a partly received frame is abandoned.
- R9: Results do not depend on the spacing between clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock, rising-edge active, free-running or gated |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_dis | input | 1 | High disables the port, low enables it |
| si | input | 1 | Serial command input, idle high |
| so | output | 1 | Serial response output, idle high |

## Verification
The bench builds the port with its default values: 14-edge writes, 20-edge reads and ID 0xA5. These make both completion points line up with the fixed reply window at edges 11 to 20. Commands are issued back to back with no idle edges between them, so each completion edge is exposed. Holding `si` low through execution and reply phases shows any early restart. Uneven gaps between edges reach the edge-counting behaviour, and a disable pulse during a partial frame reaches the abandon path.

// File: rtl/mgmt_port.sv
module mgmt_port #(
  parameter int         NR_EDGES  = 14,
  parameter int         RSP_EDGES = 20,
  parameter logic [7:0] ID_VAL    = 8'hA5
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic mgmt_dis,
  input  logic si,
  output logic so
);

  localparam int FRAME  = 9;
  localparam int RSP_SB = RSP_EDGES - FRAME;
  localparam int CW     = $clog2(RSP_EDGES + 1);
  localparam logic [CW-1:0] C_FRAME = CW'(FRAME);
  localparam logic [CW-1:0] C_SB    = CW'(RSP_SB - 1);
  localparam logic [CW-1:0] C_NEND  = CW'(NR_EDGES - 1);
  localparam logic [CW-1:0] C_REND  = CW'(RSP_EDGES - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [7:0]    rx, tx, last;
  logic [6:0]    ctrl;
  logic [7:0]    rd_val;

  always_comb
    case (rx[1:0])
      2'd0:    rd_val = {1'b0, ctrl};
      2'd1:    rd_val = ID_VAL;
      2'd2:    rd_val = ~{1'b0, ctrl};
      default: rd_val = last;
    endcase

  always_ff @(posedge sclk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; rx <= '0; tx <= '0;
      last <= '0; ctrl <= '0; so <= 1'b1;
    end else if (mgmt_dis) begin
      busy <= 1'b0; cnt <= '0; so <= 1'b1;
    end else if (!busy) begin
      so <= 1'b1;
      if (!si) begin
        busy <= 1'b1;
        cnt  <= CW'(1);
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt < C_FRAME) rx <= {si, rx[7:1]};
      if (cnt == C_FRAME) begin
        last <= rx;
        tx   <= rd_val;
        if (!rx[7]) ctrl <= rx[6:0];
      end
      if (cnt > C_FRAME) begin
        if (rx[7]) begin
          if (cnt == C_SB) so <= 1'b0;
          else if (cnt == C_REND) begin
            so <= 1'b1; busy <= 1'b0;
          end else if (cnt > C_SB) begin
            so <= tx[0]; tx <= {1'b1, tx[7:1]};
          end
        end else if (cnt == C_NEND) busy <= 1'b0;
      end
    end
  end

  a_r2_idle_so_high: assert property (@(posedge sclk) disable iff (!rst_n)
    !busy |-> so);
  a_r4_write_quiet: assert property (@(posedge sclk) disable iff (!rst_n)
    (busy && cnt > C_FRAME && !rx[7]) |-> so);
  a_r4_write_len: assert property (@(posedge sclk) disable iff (!rst_n)
    (busy && !mgmt_dis && !rx[7] && cnt == C_NEND) |=> !busy);
  a_r5_start_bit: assert property (@(posedge sclk) disable iff (!rst_n)
    (busy && !mgmt_dis && rx[7] && cnt == C_SB) |=> !so);
  a_r5_read_len: assert property (@(posedge sclk) disable iff (!rst_n)
    (busy && !mgmt_dis && rx[7] && cnt == C_REND) |=> (!busy && so));
  a_r7_cmd_frozen: assert property (@(posedge sclk) disable iff (!rst_n)
    (busy && !mgmt_dis && cnt >= C_FRAME) |=> $stable(rx));
  a_r8_dis_idle: assert property (@(posedge sclk) disable iff (!rst_n)
    mgmt_dis |=> (so && !busy));

endmodule

// File: tb/mgmt_port_test.sv
module mgmt_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic sclk = 1'b0, rst_n = 1'b0, mgmt_dis = 1'b0, si = 1'b1;
  logic so;
  int checks = 0, fails = 0;
  logic [20:0] sob;
  bit done = 0;

  mgmt_port uut (.sclk(sclk), .rst_n(rst_n), .mgmt_dis(mgmt_dis), .si(si), .so(so));

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge1(input logic b, input int low);
    si = b;
    #(low);
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input int total, input logic fill, input bit gated);
    sob = '1;
    for (int k = 1; k <= total; k++) begin
      logic b;
      if (k == 1) b = 1'b0;
      else if (k <= 9) b = cmd[k-2];
      else b = fill;
      edge1(b, gated ? (HALF + (k * 7) % 23) : HALF);
      sob[k] = so;
    end
    si = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic fill, input bit gated);
    bit quiet = 1;
    run_cmd(cmd, 14, fill, gated);
    for (int k = 1; k <= 14; k++) if (!sob[k]) quiet = 0;
    chk(quiet, "R4 write keeps so high", {7'd0, quiet}, 8'd1);
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [7:0] exp, input string req,
                         input logic fill, input bit gated);
    logic [7:0] d;
    run_cmd(cmd, 20, fill, gated);
    for (int i = 0; i < 8; i++) d[i] = sob[12+i];
    chk(sob[10] && !sob[11] && sob[20], "R5 reply framing",
        {5'd0, sob[10], sob[11], sob[20]}, 8'b101);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset;
    chk(so == 1'b1, "R1 so high after reset", {7'd0, so}, 8'd1);
    do_read(8'h80, 8'h00, "R1 control reads zero", 1'b1, 0);
  endtask

  task automatic t_idle;
    bit hi = 1;
    for (int k = 0; k < 6; k++) begin
      edge1(1'b1, HALF);
      if (!so) hi = 0;
    end
    chk(hi, "R2 idle so high", {7'd0, hi}, 8'd1);
    do_read(8'h83, 8'h80, "R2 idle high ignored, R6 sel3 prev cmd", 1'b1, 0);
  endtask

  task automatic t_write_read;
    do_write(8'h35, 1'b1, 0);
    do_read(8'h80, 8'h35, "R3 R4 control value", 1'b1, 0);
    do_read(8'h82, 8'hCA, "R6 sel2 inverse", 1'b1, 0);
    do_read(8'h81, 8'hA5, "R6 sel1 ID", 1'b1, 0);
    do_read(8'h83, 8'h81, "R6 sel3 previous command", 1'b1, 0);
    do_write(8'h7F, 1'b1, 0);
    do_read(8'h80, 8'h7F, "R3 R4 all ones", 1'b1, 0);
    do_read(8'h82, 8'h80, "R6 sel2 inverse of 7F", 1'b1, 0);
  endtask

  task automatic t_ignore_busy;
    do_write(8'h12, 1'b0, 0);
    do_read(8'h80, 8'h12, "R7 low si during write exec", 1'b0, 0);
    do_read(8'h80, 8'h12, "R7 low si during reply ignored", 1'b1, 0);
  endtask

  task automatic t_gated;
    do_write(8'h00, 1'b1, 1);
    do_read(8'h82, 8'hFF, "R9 gated edges", 1'b1, 1);
    do_read(8'h83, 8'h82, "R9 gated edges prev cmd", 1'b1, 1);
  endtask

  task automatic t_disable;
    bit hi = 1;
    do_write(8'h2C, 1'b1, 0);
    mgmt_dis = 1'b1;
    run_cmd(8'h05, 14, 1'b1, 0);
    for (int k = 1; k <= 14; k++) if (!sob[k]) hi = 0;
    chk(hi, "R8 so held high while disabled", {7'd0, hi}, 8'd1);
    mgmt_dis = 1'b0;
    edge1(1'b0, HALF); edge1(1'b1, HALF); edge1(1'b1, HALF); edge1(1'b0, HALF);
    mgmt_dis = 1'b1;
    edge1(1'b1, HALF);
    mgmt_dis = 1'b0;
    do_read(8'h80, 8'h2C, "R8 registers kept, partial frame dropped", 1'b1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'd0, 8'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) edge1(1'b1, HALF);
    rst_n = 1'b1;
    t_reset;
    t_idle;
    t_write_read;
    t_ignore_busy;
    t_gated;
    t_disable;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule